// File: doc/BRIEF.md
# Subrate HDLC Receive Processor

This block receives one HDLC channel carried in a time slot of a TDM line. Each clock with `en_i` high delivers one line bit together with its position inside the slot. A per-channel select byte marks which slot positions carry channel data. Bits at the other positions are time fill and are dropped. This lets a channel use only part of a 64 kb/s slot, for example 32 kb/s on four of the eight positions.

The surviving bit stream goes to an HDLC deframer. It locates flag octets and deletes the zero inserted after five ones. It recognises abort runs. It checks each frame's CRC-16 and its length. Frame octets, including the two FCS octets, come out LSB-first-assembled on a byte-valid strobe, and the first octet carries a start marker. Every completed frame ends with a one-cycle good or error pulse. An abandoned frame ends with an abort pulse. The state of one channel is held. Context switching between channels and writing to memory belong to the surrounding logic.

Top module: `subrate_hdlc_rx`

## Requirements
- R1: After reset all output pulses are low and the receiver hunts for a flag. No bit received before the first flag (01111110) produces any output.
- R2: A line bit is taken into the channel only when `en_i` is high and `mask_i[7 - slot_bit_i]` is set. Slot position 0 is the first bit of the slot and is selected by `mask_i[7]`. Any other bit has no effect on the outputs or on the deframer state.
- R3: A flag opens a frame and also closes the frame in progress. Flags that follow one another with no data between them report nothing.
- R4: A zero that follows five consecutive ones inside a frame is deleted from the data stream.
- R5: Every complete octet between flags is output on `byte_o` with `byte_valid_o` high for one cycle, in order. Bits are received LSB first, and the two FCS octets are included. The octet appears in the cycle after the edge that accepts the seventh data bit following its last bit.
- R6: `sof_o` is high together with `byte_valid_o` for the first octet of each frame, and only then.
- R7: The FCS is CRC-16 with reflected polynomial 0x8408, preset 0xFFFF, run over all frame bits including the FCS. The frame is good when the result is 0xF0B8. At a closing flag, a good frame pulses `frame_good_o` and any other frame pulses `frame_err_o`, in the cycle after the flag's last zero is accepted.
- R8: A frame of fewer than 32 data bits, or whose bit count is not a multiple of 8, is reported on `frame_err_o` even if its CRC matches.
- R9: Seven consecutive ones that follow at least one other data bit since the last flag pulse `abort_o` once. The receiver then hunts, and that frame gets no good or error report. Reception resumes at the next flag.
- R10: At most one of `byte_valid_o`, `frame_good_o`, `frame_err_o` and `abort_o` is high in any cycle.
- R11: A subrate select pattern such as 10111000, which selects positions 0, 2, 3 and 4, delivers the same frames and octets as a full slot. Fill bits at the unselected positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | A line bit is present this cycle |
| bit_i | input | 1 | Serial line bit |
| slot_bit_i | input | 3 | Position of the bit in its slot, 0 = first (MSB) |
| mask_i | input | 8 | Data-position select byte, bit 7 = position 0 |
| byte_valid_o | output | 1 | Received octet strobe |
| byte_o | output | 8 | Received octet |
| sof_o | output | 1 | Strobed octet is the first of its frame |
| frame_good_o | output | 1 | Frame closed with correct FCS and length |
| frame_err_o | output | 1 | Frame closed with bad FCS or bad length |
| abort_o | output | 1 | Frame abandoned by an abort run |

## Verification
An octet is due one cycle after the edge that takes the seventh data bit past its end, so it trails the line by seven delivered channel bits. Status pulses are due one cycle after the closing zero of a flag. An abort pulse is due one cycle after the seventh one. The bench pushes each expected octet and status event into a queue while it builds the line stream. A monitor samples on every falling edge and pops one entry for each pulse it sees. An extra pulse, a missing pulse, a pulse out of order or a wrong value shows up either as a mismatch or as entries still left in the queue at the end.

// File: rtl/subrate_hdlc_pkg.sv
package subrate_hdlc_pkg;
  localparam int          FLAG_TAIL   = 7;        // data bits a flag leaves in the stream
  localparam logic [15:0] CRC_POLY    = 16'h8408;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  typedef enum logic {RX_HUNT, RX_FRAME} rx_state_e;

  typedef struct packed {
    logic push;        // destuffed data bit
    logic flag;        // closing zero of 01111110
    logic seventh_one; // run of ones just reached seven
  } line_evt_t;
endpackage

// File: rtl/slot_mask_gate.sv
module slot_mask_gate #(
  parameter int SLOT_BITS = 8,
  localparam int IDX_W = $clog2(SLOT_BITS)
) (
  input  logic                 en_i,
  input  logic                 bit_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [SLOT_BITS-1:0] mask_i,
  output logic                 dv_o,
  output logic                 d_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOT_BITS - 1);
  logic [IDX_W-1:0] pos;

  assign pos  = LAST - idx_i;
  assign dv_o = en_i & mask_i[pos];
  assign d_o  = bit_i;
endmodule

// File: rtl/hdlc_line_decoder.sv
module hdlc_line_decoder import subrate_hdlc_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      dv_i,
  input  logic      d_i,
  output line_evt_t evt_o
);
  logic [2:0] ones_q;

  always_comb begin
    evt_o.flag        = dv_i & ~d_i & (ones_q == 3'd6);
    evt_o.seventh_one = dv_i &  d_i & (ones_q == 3'd6);
    evt_o.push        = dv_i & ~(~d_i & (ones_q >= 3'd5)) & ~(d_i & (ones_q >= 3'd6));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ones_q <= '0;
    else if (dv_i) ones_q <= d_i ? ((ones_q == 3'd7) ? ones_q : ones_q + 3'd1) : 3'd0;
  end
endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 import subrate_hdlc_pkg::*; #(
  parameter logic [15:0] POLY = CRC_POLY,
  parameter logic [15:0] INIT = CRC_PRESET
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        d_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_nxt;
  logic        fb;

  assign fb      = crc_q[0] ^ d_i;
  assign crc_nxt = {1'b0, crc_q[15:1]} ^ (fb ? POLY : 16'h0000);
  assign crc_o   = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (clr_i) crc_q <= INIT;
    else if (en_i)  crc_q <= crc_nxt;
  end
endmodule

// File: rtl/subrate_hdlc_rx.sv
module subrate_hdlc_rx import subrate_hdlc_pkg::*; #(
  parameter int SLOT_BITS       = 8,
  parameter int MIN_FRAME_BYTES = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         bit_i,
  input  logic [$clog2(SLOT_BITS)-1:0] slot_bit_i,
  input  logic [SLOT_BITS-1:0]         mask_i,
  output logic                         byte_valid_o,
  output logic [7:0]                   byte_o,
  output logic                         sof_o,
  output logic                         frame_good_o,
  output logic                         frame_err_o,
  output logic                         abort_o
);
  localparam int HIST_W  = 8 + FLAG_TAIL;
  localparam int CRC_TAP = HIST_W - 1 - FLAG_TAIL;
  localparam int N_LIM   = 8 * MIN_FRAME_BYTES + FLAG_TAIL;
  localparam int CNT_W   = $clog2(N_LIM + 1);
  localparam logic [CNT_W-1:0] N_MAX   = CNT_W'(N_LIM);
  localparam logic [CNT_W-1:0] N_FIRST = CNT_W'(HIST_W);
  localparam logic [CNT_W-1:0] N_CRC   = CNT_W'(FLAG_TAIL + 1);
  localparam logic [CNT_W-1:0] N_BODY  = CNT_W'(FLAG_TAIL);

  logic dv, dd;
  line_evt_t evt;
  logic [15:0] crc;

  rx_state_e        st_q;
  logic [CNT_W-1:0] n_q, n_inc;
  logic [2:0]       ph_q, ph_inc;
  logic [HIST_W-1:0] hist_q, hist_nxt;
  logic in_frame, crc_en, emit, first, close, len_ok, good, abrt;

  slot_mask_gate #(.SLOT_BITS(SLOT_BITS)) u_gate (
    .en_i   (en_i),
    .bit_i  (bit_i),
    .idx_i  (slot_bit_i),
    .mask_i (mask_i),
    .dv_o   (dv),
    .d_o    (dd)
  );

  hdlc_line_decoder u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dv_i   (dv),
    .d_i    (dd),
    .evt_o  (evt)
  );

  hdlc_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (evt.flag),
    .en_i   (crc_en),
    .d_i    (hist_nxt[CRC_TAP]),
    .crc_o  (crc)
  );

  always_comb begin
    in_frame = (st_q == RX_FRAME);
    n_inc    = (n_q == N_MAX) ? n_q : n_q + 1'b1;
    ph_inc   = ph_q + 3'd1;
    hist_nxt = {dd, hist_q[HIST_W-1:1]};
    // bits leave the tail window only once they cannot belong to a flag
    crc_en   = in_frame & evt.push & (n_inc >= N_CRC);
    emit     = in_frame & evt.push & (n_inc >= N_FIRST) & (ph_inc == 3'd7);
    first    = (n_inc == N_FIRST);
    close    = in_frame & evt.flag & (n_q >= N_CRC);
    len_ok   = (n_q == N_MAX) & (ph_q == 3'd7);
    good     = close & len_ok & (crc == CRC_RESIDUE);
    abrt     = in_frame & evt.seventh_one & (n_q >= N_BODY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_HUNT;
      n_q    <= '0;
      ph_q   <= '0;
      hist_q <= '0;
    end else if (evt.flag) begin
      st_q <= RX_FRAME;
      n_q  <= '0;
      ph_q <= '0;
    end else if (in_frame && evt.seventh_one) begin
      st_q <= RX_HUNT;
    end else if (in_frame && evt.push) begin
      n_q    <= n_inc;
      ph_q   <= ph_inc;
      hist_q <= hist_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      sof_o        <= 1'b0;
      frame_good_o <= 1'b0;
      frame_err_o  <= 1'b0;
      abort_o      <= 1'b0;
    end else begin
      byte_valid_o <= emit;
      sof_o        <= emit & first;
      frame_good_o <= good;
      frame_err_o  <= close & ~good;
      abort_o      <= abrt;
      if (emit) byte_o <= hist_nxt[7:0];
    end
  end
endmodule

// File: rtl/subrate_hdlc_rx_chk.sv
module subrate_hdlc_rx_chk #(
  parameter int SLOT_BITS = 8,
  localparam int IDX_W = $clog2(SLOT_BITS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 bit_i,
  input logic [IDX_W-1:0]     slot_bit_i,
  input logic [SLOT_BITS-1:0] mask_i,
  input logic                 byte_valid_o,
  input logic                 sof_o,
  input logic                 frame_good_o,
  input logic                 frame_err_o,
  input logic                 abort_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOT_BITS - 1);
  logic [IDX_W-1:0] pos;
  logic taken, any_evt;

  assign pos     = LAST - slot_bit_i;
  assign taken   = en_i & mask_i[pos];
  assign any_evt = byte_valid_o | frame_good_o | frame_err_o | abort_o;

  // R2
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken |=> !any_evt);

  // R10
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, frame_good_o, frame_err_o, abort_o}));

  // R6
  sof_with_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_valid_o);

  // R3
  close_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_good_o || frame_err_o) |-> !$past(bit_i));

  // R9
  abort_on_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(bit_i));

  // R9
  abort_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
endmodule

bind subrate_hdlc_rx subrate_hdlc_rx_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .bit_i        (bit_i),
  .slot_bit_i   (slot_bit_i),
  .mask_i       (mask_i),
  .byte_valid_o (byte_valid_o),
  .sof_o        (sof_o),
  .frame_good_o (frame_good_o),
  .frame_err_o  (frame_err_o),
  .abort_o      (abort_o)
);

// File: tb/tb_subrate_hdlc_rx.sv
module tb_subrate_hdlc_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int K_BYTE = 0, K_GOOD = 1, K_ERR = 2, K_ABORT = 3;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, bit_d = 1'b0;
  logic [2:0] slot_bit = '0;
  logic [7:0] mask = 8'hFF;
  logic byte_valid, sof, good, err, abrt;
  logic [7:0] byte_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  subrate_hdlc_rx dut (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .bit_i (bit_d),
    .slot_bit_i (slot_bit), .mask_i (mask),
    .byte_valid_o (byte_valid), .byte_o (byte_out), .sof_o (sof),
    .frame_good_o (good), .frame_err_o (err), .abort_o (abrt)
  );

  typedef struct {
    int         kind;
    logic [7:0] data;
    logic       sof;
    int         req;
  } exp_t;

  exp_t       exp_q[$];
  bit         line_q[$];
  logic [7:0] pl_q[$];
  int checks = 0, fails = 0, events = 0;
  int tb_ones = 0, slot_pos = 0, gap_cnt = 0;
  int m_kind;
  exp_t m_exp;

  function automatic logic [15:0] crc_step(logic [15:0] c, bit b);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(bit ok, int req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(int kind, logic [7:0] d, logic s, int req);
    exp_t e;
    e.kind = kind; e.data = d; e.sof = s; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic put_flag();
    line_q.push_back(1'b0);
    for (int i = 0; i < 6; i++) line_q.push_back(1'b1);
    line_q.push_back(1'b0);
    tb_ones = 0;
  endtask

  // R4: stuff a zero after five data ones
  task automatic put_data_bit(bit b);
    line_q.push_back(b);
    if (b) begin
      tb_ones++;
      if (tb_ones == 5) begin
        line_q.push_back(1'b0);
        tb_ones = 0;
      end
    end else tb_ones = 0;
  endtask

  task automatic put_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) put_data_bit(b[i]);
  endtask

  // R2, R11: unselected positions carry fill ones, plus idle cycles with en low
  task automatic send_line(logic [7:0] m);
    while (line_q.size() > 0) begin
      gap_cnt++;
      if (gap_cnt % 7 == 6) begin
        @(negedge clk);
        en = 1'b0; bit_d = ~bit_d;
      end
      @(negedge clk);
      en = 1'b1; mask = m; slot_bit = 3'(slot_pos);
      if (m[7 - slot_pos]) bit_d = line_q.pop_front();
      else                 bit_d = 1'b1;
      slot_pos = (slot_pos + 1) % 8;
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  // frame from pl_q; expectations follow R5-R8
  task automatic send_frame(logic [7:0] m, bit corrupt, int extra, int req);
    logic [15:0] c;
    logic [7:0]  all_b[$];
    bit          ok;
    c = 16'hFFFF;
    foreach (pl_q[i]) for (int k = 0; k < 8; k++) c = crc_step(c, pl_q[i][k]);
    c = ~c;
    if (corrupt) c[3] = ~c[3];
    all_b = pl_q;
    all_b.push_back(c[7:0]);
    all_b.push_back(c[15:8]);
    foreach (all_b[i]) expect_ev(K_BYTE, all_b[i], (i == 0), req);
    ok = !corrupt && (extra == 0) && (all_b.size() >= 4);
    expect_ev(ok ? K_GOOD : K_ERR, 8'h00, 1'b0, req);
    put_flag();
    foreach (all_b[i]) put_byte(all_b[i]);
    for (int i = 0; i < extra; i++) put_data_bit(i[0]);
    put_flag();
    send_line(m);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (byte_valid || good || err || abrt)) begin
      events++;
      m_kind = byte_valid ? K_BYTE : good ? K_GOOD : err ? K_ERR : K_ABORT;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected event: actual kind=%0d data=%02h expected none",
                 m_kind, byte_out);
      end else begin
        m_exp = exp_q.pop_front();
        if (m_kind != m_exp.kind ||
            (m_kind == K_BYTE && (byte_out != m_exp.data || sof != m_exp.sof))) begin
          fails++;
          $display("FAIL R%0d event: actual kind=%0d data=%02h sof=%0d expected kind=%0d data=%02h sof=%0d",
                   m_exp.req, m_kind, byte_out, sof, m_exp.kind, m_exp.data, m_exp.sof);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++; checks++;
    $display("FAIL R5 watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({byte_valid, sof, good, err, abrt} == 5'b0, 1, "outputs after reset",
          {byte_valid, sof, good, err, abrt}, 0);

    // R1: zeros and ones without a flag give nothing
    for (int i = 0; i < 40; i++) line_q.push_back(i % 5 == 0);
    send_line(8'hFF);
    repeat (3) @(negedge clk);
    check(events == 0, 1, "events before first flag", events, 0);

    // R3: idle flags only
    put_flag(); put_flag(); put_flag();
    send_line(8'hFF);
    repeat (3) @(negedge clk);
    check(events == 0, 3, "events on idle flags", events, 0);

    // R5 R6 R7: plain good frame
    pl_q = '{8'h01, 8'h02, 8'h03, 8'h04};
    send_frame(8'hFF, 1'b0, 0, 7);

    // R4: data needing zero insertion
    pl_q = '{8'hFF, 8'h7E, 8'hFC, 8'h1F};
    send_frame(8'hFF, 1'b0, 0, 4);

    // R11: subrate pattern 10111000
    pl_q = '{8'hA5, 8'h5A, 8'hC3};
    send_frame(8'b1011_1000, 1'b0, 0, 11);

    // R2: half-slot pattern
    pl_q = '{8'h3C, 8'h81};
    send_frame(8'hF0, 1'b0, 0, 2);

    // R7: corrupted FCS
    pl_q = '{8'h11, 8'h22, 8'h33};
    send_frame(8'hFF, 1'b1, 0, 7);

    // R8: too short, valid CRC
    pl_q = '{8'h42};
    send_frame(8'hFF, 1'b0, 0, 8);

    // R8: bit count not a multiple of 8
    pl_q = '{8'h10, 8'h20, 8'h30};
    send_frame(8'hFF, 1'b0, 3, 8);

    // R9: abort after two octets; only the first octet is past the tail window
    expect_ev(K_BYTE, 8'h12, 1'b1, 9);
    expect_ev(K_ABORT, 8'h00, 1'b0, 9);
    put_flag(); put_byte(8'h12); put_byte(8'h34);
    for (int i = 0; i < 10; i++) line_q.push_back(1'b1);
    send_line(8'hFF);
    // R9: recovery at next flag
    pl_q = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
    send_frame(8'hFF, 1'b0, 0, 9);

    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, 5, "expected events left over", exp_q.size(), 0);
    check(events > 30, 5, "event count", events, 31);
    finish_run();
  end
endmodule